// File: doc/BRIEF.md
# Key-Protected Control Register File

This block is a bank of 32-bit control and status words for a system controller. It sits behind a simple request/response port: one request per cycle carrying a byte address, an access size, a write flag and write data, answered one cycle later with read data and an error flag. Every register except the unlock word is write-protected until software writes a 32-bit magic key to the unlock word. Writing any other value to the unlock word locks the bank again.

Control words are written through a pair of addresses. The set address ORs in the written ones. The clear address, one word higher, removes the written ones. Strap words use the same pairing, and each has a protect word two words above it that freezes the set path. Revision, identifier and random-number words cannot be written. The random word returns a fresh LFSR value on every read. Three PLL extension words always read with their lock bit set.

Strap, revision and key-state values come from input ports and are captured on the first clock edge after reset is released. The two control words and the two strap words also drive output ports for the logic they configure.

Top module: `kreg_bank`

## Requirements
- R1: The register index is the byte address divided by 4. An access is accepted only when `req_size` is 2 (4 bytes) and address bits [1:0] are 0. Any other access changes nothing, reads back 0 and flags an error.
- R2: The unlock word sits at byte 0x00 and reads 1 or 0. A write of exactly `KEY` (default 32'h5EC0_A11E) stores 1 and any other value stores 0. While it holds 0, every write to another index is dropped with an error.
- R3: Writing a set address (0x10 for control word 0, 0x18 for control word 1) ORs the data into the stored word. Bits written as 0 stay unchanged.
- R4: The clear address is one word above its set address (0x14, 0x1C, 0x24, 0x34). A write there clears every stored bit that is 1 in the data. A clear address always reads 0.
- R5: Strap words are at 0x20 and 0x30. Their protect words are at 0x28 and 0x38. While a protect word is nonzero, set writes to its strap word are dropped with an error. The strap clear address still clears.
- R6: Writes to the fixed revision (0x04), loaded revision (0x08), chip identifier (0x0C) and random word (0x4C) change nothing and flag an error.
- R7: The PLL extension words at 0x40, 0x44 and 0x48 store all 32 written bits, but always read with bit 31 set to 1.
- R8: A read of 0x4C returns the current state of a 32-bit LFSR and then advances it. The LFSR starts at `LFSR_SEED` (default 32'hACE1_2468) and steps as next = {s[30:0], s[31]^s[21]^s[1]^s[0]}. No other access moves the LFSR.
- R9: An index at or above `NUM_REGS` (default 24, so byte 0x60 and up) reads 0, ignores writes and flags an error.
- R10: After reset:
  - control word 0 reads 32'h00FF_0F0F and control word 1 reads 32'hFFFF_0000;
  - 0x04 reads `REV_FIXED` (default 32'h0A01_0003) and 0x0C reads `CHIP_ID` (default 32'hC0DE_5A17);
  - on the first clock edge after reset release, the strap words load `strap0_in` and `strap1_in`, 0x08 loads `rev_in`, and the unlock word loads 1 if `key_state_in` is nonzero;
  - every other stored word reads 0.
- R11: `rsp_valid` is high for exactly the one cycle after each request. `rsp_err` and `rsp_rdata` are valid in that same cycle, and `rsp_rdata` is 0 for writes.
- R12: `ctl0_q`, `ctl1_q`, `strap0_q` and `strap1_q` always equal the stored values of control words 0 and 1 and strap words 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| strap0_in | input | 32 | Value captured into strap word 0 after reset |
| strap1_in | input | 32 | Value captured into strap word 1 after reset |
| rev_in | input | 32 | Value captured into the loaded revision word after reset |
| key_state_in | input | 32 | A nonzero value makes the bank come up unlocked |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access size as log2 of the byte count; only 2 is accepted |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Access was rejected or dropped |
| ctl0_q | output | 32 | Stored control word 0 |
| ctl1_q | output | 32 | Stored control word 1 |
| strap0_q | output | 32 | Stored strap word 0 |
| strap1_q | output | 32 | Stored strap word 1 |

## Verification
A wrong unlock bit shows up on the very next response. A write that should have been dropped completes with no error, or an accepted write comes back flagged, and the unlock word reads the wrong value. A corrupted set/clear path or protect gate shows up on the next read of that word. It also shows up at once on the control and strap output ports, with no read needed. An LFSR that has stepped when it should not have, or has the wrong taps, shows up on the next read of the random word as a value off the expected sequence.

// File: rtl/kreg_pkg.sv
`timescale 1ns/1ps
package kreg_pkg;

  typedef enum logic [3:0] {
    K_KEY,       // unlock word
    K_FIXED_REV, // constant revision
    K_LOAD_REV,  // revision captured from a port
    K_FIXED_ID,  // constant chip identifier
    K_SET,       // write-1-to-set storage
    K_CLR,       // write-1-to-clear alias, no storage
    K_PROT,      // strap protect word
    K_PLLX,      // PLL extension, lock bit forced on read
    K_RNG,       // LFSR random word
    K_RW         // plain storage
  } reg_kind_e;

  localparam int IX_KEY    = 0;
  localparam int IX_REVA   = 1;
  localparam int IX_REVB   = 2;
  localparam int IX_CHIP   = 3;
  localparam int IX_CTL0   = 4;
  localparam int IX_CTL1   = 6;
  localparam int IX_STRAP0 = 8;
  localparam int IX_STRAP1 = 12;
  localparam int IX_PLLX0  = 16;
  localparam int IX_RNG    = 19;
  localparam int MIN_REGS  = 24;

  localparam logic [31:0] CTL0_RST = 32'h00FF_0F0F;
  localparam logic [31:0] CTL1_RST = 32'hFFFF_0000;
  localparam logic [31:0] PLL_LOCK = 32'h8000_0000;

  function automatic reg_kind_e kind_of(input int i);
    case (i)
      IX_KEY:                        return K_KEY;
      IX_REVA:                       return K_FIXED_REV;
      IX_REVB:                       return K_LOAD_REV;
      IX_CHIP:                       return K_FIXED_ID;
      IX_CTL0, IX_CTL1,
      IX_STRAP0, IX_STRAP1:          return K_SET;
      IX_CTL0 + 1, IX_CTL1 + 1,
      IX_STRAP0 + 1, IX_STRAP1 + 1:  return K_CLR;
      IX_STRAP0 + 2, IX_STRAP1 + 2:  return K_PROT;
      IX_PLLX0, IX_PLLX0 + 1,
      IX_PLLX0 + 2:                  return K_PLLX;
      IX_RNG:                        return K_RNG;
      default:                       return K_RW;
    endcase
  endfunction

  function automatic bit is_strap(input int i);
    return (i == IX_STRAP0) || (i == IX_STRAP1);
  endfunction

  function automatic logic [31:0] rst_val(input int i);
    if (i == IX_CTL0) return CTL0_RST;
    if (i == IX_CTL1) return CTL1_RST;
    return 32'h0;
  endfunction

  function automatic logic [31:0] lfsr_next(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

endpackage

// File: rtl/kreg_decode.sv
`timescale 1ns/1ps
module kreg_decode #(
  parameter int ADDR_W   = 12,
  parameter int NUM_REGS = 24,
  parameter int IDX_W    = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic [IDX_W-1:0]  idx,
  output logic              in_range,
  output logic              aligned
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;

  assign word     = addr[ADDR_W-1:2];
  assign in_range = (32'(word) < 32'(NUM_REGS));
  assign idx      = word[IDX_W-1:0];
  assign aligned  = (addr[1:0] == 2'b00) && (size == 2'd2);
endmodule

// File: rtl/kreg_lfsr.sv
`timescale 1ns/1ps
module kreg_lfsr
  import kreg_pkg::*;
#(
  parameter logic [31:0] SEED = 32'hACE1_2468
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv,
  output logic [31:0] state
);
  logic [31:0] state_d;

  always_comb begin
    state_d = lfsr_next(state);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state <= SEED;
    else if (adv) state <= state_d;
  end
endmodule

// File: rtl/kreg_cell.sv
`timescale 1ns/1ps
module kreg_cell
  import kreg_pkg::*;
#(
  parameter reg_kind_e   KIND     = K_RW,
  parameter logic [31:0] RST_VAL  = 32'h0,
  parameter bit          IS_STRAP = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        wr_hit,
  input  logic        clr_hit,
  input  logic        guard,
  input  logic [31:0] wdata,
  input  logic [31:0] load_val,
  output logic [31:0] q
);
  logic [31:0] d;
  logic        en;

  always_comb begin
    d  = q;
    en = 1'b0;
    case (KIND)
      K_SET: begin
        if (init && IS_STRAP) begin
          en = 1'b1;
          d  = load_val;
        end else if (wr_hit && !guard) begin
          en = 1'b1;
          d  = q | wdata;
        end else if (clr_hit) begin
          en = 1'b1;
          d  = q & ~wdata;
        end
      end
      K_LOAD_REV: begin
        if (init) begin
          en = 1'b1;
          d  = load_val;
        end
      end
      default: begin
        if (wr_hit) begin
          en = 1'b1;
          d  = wdata;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST_VAL;
    else if (en) q <= d;
  end
endmodule

// File: rtl/kreg_bank.sv
`timescale 1ns/1ps
module kreg_bank
  import kreg_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          NUM_REGS  = 24,
  parameter logic [31:0] KEY       = 32'h5EC0_A11E,
  parameter logic [31:0] REV_FIXED = 32'h0A01_0003,
  parameter logic [31:0] CHIP_ID   = 32'hC0DE_5A17,
  parameter logic [31:0] LFSR_SEED = 32'hACE1_2468
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       strap0_in,
  input  logic [31:0]       strap1_in,
  input  logic [31:0]       rev_in,
  input  logic [31:0]       key_state_in,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic [31:0]       ctl0_q,
  output logic [31:0]       ctl1_q,
  output logic [31:0]       strap0_q,
  output logic [31:0]       strap1_q
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [IDX_W-1:0]    idx;
  logic                in_range, aligned, acc_ok;
  logic                init_q;
  logic                unlock_q, unlock_d, unlock_en;
  logic                wr_req, rd_req, wr_ok, wr_err, rd_err;
  logic                lock_block, ro_target, lfsr_adv;
  reg_kind_e           req_kind;
  logic [31:0]         lfsr_state;
  logic [31:0]         rd_data;
  logic [NUM_REGS-1:0] guard_vec;
  logic [31:0]         store_q [NUM_REGS];
  logic [31:0]         view    [NUM_REGS];
  logic                rsp_valid_d, rsp_err_d;
  logic [31:0]         rsp_rdata_d;

  kreg_decode #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)
  ) i_decode (
    .addr(req_addr), .size(req_size), .idx(idx),
    .in_range(in_range), .aligned(aligned)
  );

  kreg_lfsr #(.SEED(LFSR_SEED)) i_lfsr (
    .clk(clk), .rst_n(rst_n), .adv(lfsr_adv), .state(lfsr_state)
  );

  // request qualification
  always_comb begin
    acc_ok     = in_range && aligned;
    wr_req     = req_valid && req_write;
    rd_req     = req_valid && !req_write;
    req_kind   = kind_of(int'(idx));
    ro_target  = (req_kind == K_FIXED_REV) || (req_kind == K_LOAD_REV) ||
                 (req_kind == K_FIXED_ID)  || (req_kind == K_RNG);
    lock_block = !unlock_q && (idx != '0);
    wr_ok      = wr_req && acc_ok && !lock_block && !ro_target && !guard_vec[idx];
    wr_err     = wr_req && !wr_ok;
    rd_err     = rd_req && !acc_ok;
    lfsr_adv   = rd_req && acc_ok && (req_kind == K_RNG);
    rd_data    = acc_ok ? view[idx] : 32'h0;
  end

  // first-edge capture after reset release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      init_q <= 1'b1;
    else if (init_q) init_q <= 1'b0;
  end

  // unlock word
  always_comb begin
    unlock_d  = unlock_q;
    unlock_en = 1'b0;
    if (init_q) begin
      unlock_en = 1'b1;
      unlock_d  = |key_state_in;
    end else if (wr_ok && (idx == '0)) begin
      unlock_en = 1'b1;
      unlock_d  = (req_wdata == KEY);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         unlock_q <= 1'b0;
    else if (unlock_en) unlock_q <= unlock_d;
  end

  // register array, one slice per index, variant chosen by the map
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam reg_kind_e KI = kind_of(i);
    if (KI == K_KEY) begin : g_key
      assign store_q[i]   = 32'h0;
      assign view[i]      = {31'h0, unlock_q};
      assign guard_vec[i] = 1'b0;
    end else if (KI == K_FIXED_REV) begin : g_reva
      assign store_q[i]   = 32'h0;
      assign view[i]      = REV_FIXED;
      assign guard_vec[i] = 1'b0;
    end else if (KI == K_FIXED_ID) begin : g_chip
      assign store_q[i]   = 32'h0;
      assign view[i]      = CHIP_ID;
      assign guard_vec[i] = 1'b0;
    end else if (KI == K_CLR) begin : g_clr
      assign store_q[i]   = 32'h0;
      assign view[i]      = 32'h0;
      assign guard_vec[i] = 1'b0;
    end else if (KI == K_RNG) begin : g_rng
      assign store_q[i]   = 32'h0;
      assign view[i]      = lfsr_state;
      assign guard_vec[i] = 1'b0;
    end else begin : g_store
      logic        wr_hit, clr_hit, guard_w;
      logic [31:0] load_w;

      assign wr_hit = wr_ok && (idx == IDX_W'(i));

      if (KI == K_SET) begin : g_clr_path
        assign clr_hit = wr_ok && (idx == IDX_W'(i + 1));
      end else begin : g_no_clr
        assign clr_hit = 1'b0;
      end

      if (is_strap(i)) begin : g_guard
        assign guard_w = |store_q[i + 2];
      end else begin : g_no_guard
        assign guard_w = 1'b0;
      end

      if (i == IX_STRAP0) begin : g_ld_s0
        assign load_w = strap0_in;
      end else if (i == IX_STRAP1) begin : g_ld_s1
        assign load_w = strap1_in;
      end else if (KI == K_LOAD_REV) begin : g_ld_rev
        assign load_w = rev_in;
      end else begin : g_ld_none
        assign load_w = 32'h0;
      end

      kreg_cell #(
        .KIND(KI), .RST_VAL(rst_val(i)), .IS_STRAP(is_strap(i))
      ) i_cell (
        .clk(clk), .rst_n(rst_n), .init(init_q),
        .wr_hit(wr_hit), .clr_hit(clr_hit), .guard(guard_w),
        .wdata(req_wdata), .load_val(load_w), .q(store_q[i])
      );

      assign guard_vec[i] = guard_w;
      if (KI == K_PLLX) begin : g_pll_view
        assign view[i] = store_q[i] | PLL_LOCK;
      end else begin : g_plain_view
        assign view[i] = store_q[i];
      end
    end
  end

  // response stage
  always_comb begin
    rsp_valid_d = req_valid;
    rsp_err_d   = wr_err || rd_err;
    rsp_rdata_d = rd_req ? rd_data : 32'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= 32'h0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_err   <= rsp_err_d;
      rsp_rdata <= rsp_rdata_d;
    end
  end

  assign ctl0_q   = store_q[IX_CTL0];
  assign ctl1_q   = store_q[IX_CTL1];
  assign strap0_q = store_q[IX_STRAP0];
  assign strap1_q = store_q[IX_STRAP1];
endmodule

// File: rtl/kreg_bank_chk.sv
`timescale 1ns/1ps
module kreg_bank_chk
  import kreg_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int NUM_REGS = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic [31:0]       req_wdata,
  input logic              rsp_valid,
  input logic [31:0]       rsp_rdata,
  input logic              rsp_err,
  input logic [31:0]       ctl0_q,
  input logic              unlock,
  input logic              init
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              word_ok, pll_rd;

  assign word    = req_addr[ADDR_W-1:2];
  assign word_ok = (req_addr[1:0] == 2'b00) && (req_size == 2'd2);
  assign pll_rd  = req_valid && !req_write && word_ok &&
                   (32'(word) >= 32'(IX_PLLX0)) && (32'(word) <= 32'(IX_PLLX0 + 2));

  assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_no_spurious_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_locked_write_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !unlock && (word != '0)) |=> rsp_err);

  assert_locked_ctl_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !unlock) |=> $stable(ctl0_q));

  assert_oor_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && (32'(word) >= 32'(NUM_REGS))) |=> (rsp_err && (rsp_rdata == 32'h0)));

  assert_set_keeps_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && word_ok && unlock && !init && (32'(word) == 32'(IX_CTL0)))
    |=> ((ctl0_q & $past(req_wdata)) == $past(req_wdata)));

  assert_pll_lock_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pll_rd |=> rsp_rdata[31]);
endmodule

bind kreg_bank kreg_bank_chk #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
  .ctl0_q(ctl0_q), .unlock(unlock_q), .init(init_q)
);

// File: tb/test_kreg_bank.sv
`timescale 1ns/1ps
module test_kreg_bank;
  localparam logic [31:0] KEY_V  = 32'h5EC0_A11E;
  localparam logic [31:0] REVA_V = 32'h0A01_0003;
  localparam logic [31:0] CHIP_V = 32'hC0DE_5A17;
  localparam logic [31:0] SEED_V = 32'hACE1_2468;
  localparam logic [31:0] S0_V   = 32'h0000_1234;
  localparam logic [31:0] S1_V   = 32'hBEEF_0000;
  localparam logic [31:0] REVB_V = 32'h0302_0001;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] strap0_in, strap1_in, rev_in, key_state_in;
  logic        req_valid, req_write;
  logic [11:0] req_addr;
  logic [1:0]  req_size;
  logic [31:0] req_wdata;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata, ctl0_q, ctl1_q, strap0_q, strap1_q;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  kreg_bank i_kreg_bank (
    .clk(clk), .rst_n(rst_n), .strap0_in(strap0_in), .strap1_in(strap1_in),
    .rev_in(rev_in), .key_state_in(key_state_in), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .ctl0_q(ctl0_q), .ctl1_q(ctl1_q),
    .strap0_q(strap0_q), .strap1_q(strap1_q)
  );

  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit wr, input logic [11:0] a, input logic [1:0] sz,
                     input logic [31:0] wd, output logic [31:0] rd,
                     output logic er, output logic vl);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    @(negedge clk);
    rd = rsp_rdata; er = rsp_err; vl = rsp_valid;
    req_valid = 1'b0; req_write = 1'b0; req_wdata = 32'h0;
  endtask

  task automatic wr32(input logic [11:0] a, input logic [31:0] d, output logic er);
    logic [31:0] rd; logic vl;
    acc(1'b1, a, 2'd2, d, rd, er, vl);
  endtask

  task automatic rd32(input logic [11:0] a, output logic [31:0] rd, output logic er);
    logic vl;
    acc(1'b0, a, 2'd2, 32'h0, rd, er, vl);
  endtask

  task automatic do_reset(input logic [31:0] kst);
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_size = 2'd2; req_wdata = '0;
    strap0_in = S0_V; strap1_in = S1_V; rev_in = REVB_V; key_state_in = kst;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] r; logic e;
    rd32(12'h000, r, e); check("R10 key loads 0 from key_state_in", r, 32'h0);
    rd32(12'h004, r, e); check("R10 fixed revision", r, REVA_V);
    rd32(12'h008, r, e); check("R10 loaded revision", r, REVB_V);
    rd32(12'h00C, r, e); check("R10 chip id", r, CHIP_V);
    rd32(12'h010, r, e); check("R10 ctl0 default", r, 32'h00FF_0F0F);
    rd32(12'h018, r, e); check("R10 ctl1 default", r, 32'hFFFF_0000);
    rd32(12'h020, r, e); check("R10 strap0 from port", r, S0_V);
    rd32(12'h030, r, e); check("R10 strap1 from port", r, S1_V);
    rd32(12'h050, r, e); check("R10 plain word zero", r, 32'h0);
    check("R12 strap0_q port", strap0_q, S0_V);
    check("R12 ctl1_q port", ctl1_q, 32'hFFFF_0000);
  endtask

  task automatic t_timing;
    logic [31:0] r; logic e, v;
    acc(1'b0, 12'h004, 2'd2, 32'h0, r, e, v);
    check("R11 rsp_valid after request", {31'h0, v}, 32'h1);
    check("R11 no error on good read", {31'h0, e}, 32'h0);
    @(negedge clk);
    check("R11 rsp_valid drops when idle", {31'h0, rsp_valid}, 32'h0);
    acc(1'b1, 12'h050, 2'd2, 32'h0, r, e, v);
    check("R11 write response rdata zero", r, 32'h0);
  endtask

  task automatic t_lock;
    logic [31:0] r; logic e;
    wr32(12'h010, 32'hF000_0000, e); check("R2 locked write err", {31'h0, e}, 32'h1);
    rd32(12'h010, r, e); check("R2 locked write dropped", r, 32'h00FF_0F0F);
    check("R12 ctl0_q unchanged when locked", ctl0_q, 32'h00FF_0F0F);
    wr32(12'h000, 32'h1234_5678, e); rd32(12'h000, r, e); check("R2 wrong key stores 0", r, 32'h0);
    wr32(12'h000, KEY_V, e); check("R2 key write no err", {31'h0, e}, 32'h0);
    rd32(12'h000, r, e); check("R2 key stores 1", r, 32'h1);
  endtask

  task automatic t_set_clear;
    logic [31:0] r; logic e;
    wr32(12'h010, 32'h0000_F000, e); rd32(12'h010, r, e); check("R3 set ORs in", r, 32'h00FF_FF0F);
    wr32(12'h014, 32'h000F_000F, e); rd32(12'h010, r, e); check("R4 clear removes ones", r, 32'h00F0_FF00);
    rd32(12'h014, r, e); check("R4 clear alias reads 0", r, 32'h0);
    check("R12 ctl0_q after set/clear", ctl0_q, 32'h00F0_FF00);
    wr32(12'h01C, 32'hFFFF_0000, e); wr32(12'h018, 32'h0000_00A5, e);
    rd32(12'h018, r, e); check("R3 ctl1 set after clear", r, 32'h0000_00A5);
    check("R12 ctl1_q port", ctl1_q, 32'h0000_00A5);
  endtask

  task automatic t_strap;
    logic [31:0] r; logic e;
    wr32(12'h020, 32'h0001_0000, e); rd32(12'h020, r, e); check("R5 strap set unprotected", r, 32'h0001_1234);
    wr32(12'h028, 32'h1, e);
    wr32(12'h020, 32'h8000_0000, e); check("R5 protected strap write err", {31'h0, e}, 32'h1);
    rd32(12'h020, r, e); check("R5 protected strap unchanged", r, 32'h0001_1234);
    wr32(12'h024, 32'h0000_0004, e); rd32(12'h020, r, e); check("R5 clear still acts", r, 32'h0001_1230);
    wr32(12'h028, 32'h0, e); wr32(12'h020, 32'h8000_0000, e);
    rd32(12'h020, r, e); check("R5 set after unprotect", r, 32'h8001_1230);
    wr32(12'h038, 32'h7, e); wr32(12'h030, 32'h1, e);
    check("R12 strap1_q protected", strap1_q, S1_V);
  endtask

  task automatic t_ro;
    logic [31:0] r; logic e;
    wr32(12'h004, 32'hFFFF_FFFF, e); check("R6 revision write err", {31'h0, e}, 32'h1);
    rd32(12'h004, r, e); check("R6 revision unchanged", r, REVA_V);
    wr32(12'h008, 32'h0, e); rd32(12'h008, r, e); check("R6 loaded revision unchanged", r, REVB_V);
    wr32(12'h00C, 32'h0, e); rd32(12'h00C, r, e); check("R6 chip id unchanged", r, CHIP_V);
    wr32(12'h04C, 32'h0, e); check("R6 random word write err", {31'h0, e}, 32'h1);
  endtask

  task automatic t_pll;
    logic [31:0] r; logic e;
    rd32(12'h040, r, e); check("R7 pll0 lock bit at reset", r, 32'h8000_0000);
    wr32(12'h044, 32'h0000_1234, e); rd32(12'h044, r, e); check("R7 pll1 forced bit31", r, 32'h8000_1234);
    wr32(12'h02C, 32'h1357_9BDF, e); rd32(12'h02C, r, e); check("R7 plain word no forcing", r, 32'h1357_9BDF);
  endtask

  task automatic t_rng;
    logic [31:0] r; logic e;
    logic [31:0] s = SEED_V;
    rd32(12'h04C, r, e); check("R8 first random = seed", r, s);
    s = step(s);
    rd32(12'h050, r, e);
    rd32(12'h04C, r, e); check("R8 second random", r, s);
    s = step(s);
    rd32(12'h04C, r, e); check("R8 third random", r, s);
  endtask

  task automatic t_range;
    logic [31:0] r; logic e, v;
    rd32(12'h060, r, e); check("R9 oor read zero", r, 32'h0); check("R9 oor read err", {31'h0, e}, 32'h1);
    wr32(12'h060, 32'hFFFF_FFFF, e); check("R9 oor write err", {31'h0, e}, 32'h1);
    rd32(12'hFFC, r, e); check("R9 top address zero", r, 32'h0);
    wr32(12'h050, 32'hAAAA_5555, e);
    acc(1'b1, 12'h052, 2'd2, 32'h1111_1111, r, e, v); check("R1 misaligned write err", {31'h0, e}, 32'h1);
    acc(1'b1, 12'h050, 2'd1, 32'h2222_2222, r, e, v); check("R1 halfword write err", {31'h0, e}, 32'h1);
    rd32(12'h050, r, e); check("R1 bad writes no effect", r, 32'hAAAA_5555);
    acc(1'b0, 12'h050, 2'd0, 32'h0, r, e, v); check("R1 byte read returns 0", r, 32'h0);
    check("R1 byte read err", {31'h0, e}, 32'h1);
  endtask

  task automatic t_relock;
    logic [31:0] r; logic e;
    wr32(12'h000, 32'h0, e); wr32(12'h010, 32'h0000_0001, e);
    check("R2 relocked write err", {31'h0, e}, 32'h1);
    check("R2 relocked ctl0 unchanged", ctl0_q, 32'h00F0_FF00);
    do_reset(32'h5);
    rd32(12'h000, r, e); check("R10 key_state_in nonzero unlocks", r, 32'h1);
    wr32(12'h010, 32'h0000_0001, e); rd32(12'h010, r, e); check("R10 unlocked out of reset", r, 32'h00FF_0F0F);
  endtask

  initial begin
    do_reset(32'h0);
    t_reset();
    t_timing();
    t_lock();
    t_set_clear();
    t_strap();
    t_ro();
    t_pll();
    t_rng();
    t_range();
    t_relock();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R11 watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule